// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit RISC execute pipe. A 4-bit operation code selects one of sixteen operations on two operands. The second operand arrives already shifted, along with the carry bit that the shifter produced and a marker that says the shift was a left shift by zero. The block returns the result straight away on the same cycle, together with a write-enable that tells the register file whether the result is stored.

Four condition flags, N, Z, C and V, are held in a small register inside the block. When flag setting is requested and the destination is not the program counter, the new flag values are captured on the next rising clock edge. The carry-chained operations (add with carry, and the two subtracts with borrow) read the held C flag as their carry input.

Subtraction is done as A + NOT B + carry-in. For this reason C reads as "no borrow" after any subtract. Logical operations take C from the shifter and never touch V. Arithmetic operations take both C and V from the adder.

Top module: `dp_alu_core`

## Requirements
- R1: Logical opcodes give these results: AND (0000) and TST (1000) give A AND B; EOR (0001) and TEQ (1001) give A XOR B; ORR (1100) gives A OR B; MOV (1101) gives B; BIC (1110) gives A AND NOT B; MVN (1111) gives NOT B. The `result` port shows the value in the same cycle as the inputs.
- R2: Plain arithmetic opcodes give these results modulo 2^32: SUB (0010) and CMP (1010) give A − B; RSB (0011) gives B − A; ADD (0100) and CMN (1011) give A + B.
- R3: Carry-chained opcodes use the held C flag (c): ADC (0101) gives A + B + c; SBC (0110) gives A − B + c − 1; RSC (0111) gives B − A + c − 1.
- R4: `write_en` is 0 for the four opcodes 10xx (TST, TEQ, CMP, CMN) and 1 for every other opcode.
- R5: `flags_nzcv` is packed as N = bit 3, Z = bit 2, C = bit 1, V = bit 0. An update happens when `set_flags`=1 and `dest_is_pc`=0. On the rising clock edge after an update, N holds bit 31 of the result and Z holds 1 exactly when the result is zero.
- R6: After an update by an arithmetic opcode, C holds the carry out of bit 31 of A + B', where B' is B, or its inverse for a subtract. C is therefore 1 when a subtract does not borrow. V holds 1 exactly when the signed result overflows.
- R7: After an update by a logical opcode, V keeps its previous value. C takes `shift_carry` when `shift_is_lsl0`=0 and keeps its previous value when `shift_is_lsl0`=1.
- R8: When `set_flags`=0 or `dest_is_pc`=1, `flags_nzcv` does not change at the clock edge.
- R9: While `rst_n` is low, `flags_nzcv` is 0000, and the reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter |
| shift_is_lsl0 | input | 1 | The shift was a left shift by zero |
| set_flags | input | 1 | Request a flag update |
| dest_is_pc | input | 1 | Destination is the program counter; this blocks the update |
| result | output | 32 | Operation result |
| write_en | output | 1 | Result is to be written back |
| flags_nzcv | output | 4 | Held N, Z, C, V flags |

## Verification
Two functions meet on one clock edge for a carry-chained opcode: the held C feeds the adder, and that same edge overwrites C with the new carry out. The bench provokes this by first setting C to a chosen value with a flag-setting MOV and then issuing ADC, SBC or RSC with corner operands. It judges the result in the same cycle against a wide-integer model that uses the old C, and then judges the new flags after the edge. A second overlap, where a logical update rewrites N and Z while it must preserve C under a zero-length left shift and preserve V, is provoked by applying a logical opcode after an arithmetic one has set both C and V.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_arith(alu_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_flag_only(alu_op_e op);
        case (op)
            OP_TST, OP_TEQ, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_held,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic [W:0]   wide;

    always_comb begin
        case (op)
            OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1;       end
            OP_RSB:         begin x = b; y = ~a; cin = 1'b1;       end
            OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0;       end
            OP_ADC:         begin x = a; y = b;  cin = carry_held; end
            OP_SBC:         begin x = a; y = ~b; cin = carry_held; end
            OP_RSC:         begin x = b; y = ~a; cin = carry_held; end
            default:        begin x = '0; y = '0; cin = 1'b0;      end
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  nzcv_t nxt,
    output nzcv_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (upd) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         shift_carry,
    input  logic         shift_is_lsl0,
    input  logic         set_flags,
    input  logic         dest_is_pc,
    output logic [W-1:0] result,
    output logic         write_en,
    output logic [3:0]   flags_nzcv
);

    alu_op_e      op_e;
    logic [W-1:0] logic_y;
    logic [W-1:0] add_y;
    logic         add_c;
    logic         add_v;
    logic         arith;
    logic         upd;
    nzcv_t        held;
    nzcv_t        nxt;

    assign op_e = alu_op_e'(opcode);

    dp_alu_logic #(.W(W)) u_logic (
        .op (op_e),
        .a  (op_a),
        .b  (op_b),
        .y  (logic_y)
    );

    dp_alu_adder #(.W(W)) u_adder (
        .op         (op_e),
        .a          (op_a),
        .b          (op_b),
        .carry_held (held.c),
        .sum        (add_y),
        .cout       (add_c),
        .ovf        (add_v)
    );

    assign arith    = op_is_arith(op_e);
    assign result   = arith ? add_y : logic_y;
    assign write_en = !op_is_flag_only(op_e);
    assign upd      = set_flags && !dest_is_pc;

    always_comb begin
        nxt.n = result[W-1];
        nxt.z = ~|result;
        if (arith) begin
            nxt.c = add_c;
            nxt.v = add_v;
        end else begin
            nxt.c = shift_is_lsl0 ? held.c : shift_carry;
            nxt.v = held.v;
        end
    end

    dp_alu_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .nxt   (nxt),
        .q     (held)
    );

    assign flags_nzcv = held;

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   opcode,
    input logic [W-1:0] op_b,
    input logic         shift_is_lsl0,
    input logic         set_flags,
    input logic         dest_is_pc,
    input logic [W-1:0] result,
    input logic         write_en,
    input logic [3:0]   flags_nzcv
);

    logic logical_op;
    logic test_form;
    assign logical_op = !op_is_arith(alu_op_e'(opcode));
    assign test_form  = (opcode == OP_TST) || (opcode == OP_TEQ) ||
                        (opcode == OP_CMP) || (opcode == OP_CMN);

    AST_MOV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_MOV) |-> (result == op_b)); // R1

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        test_form |-> !write_en); // R4

    AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && !dest_is_pc) |=> (flags_nzcv[3] == $past(result[W-1]))); // R5

    AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && !dest_is_pc) |=> (flags_nzcv[2] == ($past(result) == '0))); // R5

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && !dest_is_pc && logical_op) |=> $stable(flags_nzcv[0])); // R7

    AST_LSL0_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && !dest_is_pc && logical_op && shift_is_lsl0) |=> $stable(flags_nzcv[1])); // R7

    AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_flags && !dest_is_pc) |=> $stable(flags_nzcv)); // R8

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (flags_nzcv == 4'b0000); // R9
        end
    end

endmodule

bind dp_alu_core dp_alu_checker #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .opcode        (opcode),
    .op_b          (op_b),
    .shift_is_lsl0 (shift_is_lsl0),
    .set_flags     (set_flags),
    .dest_is_pc    (dest_is_pc),
    .result        (result),
    .write_en      (write_en),
    .flags_nzcv    (flags_nzcv)
);

// File: tb/dp_alu_core_test.sv
module dp_alu_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  opcode;
    logic [31:0] op_a, op_b;
    logic        shift_carry, shift_is_lsl0, set_flags, dest_is_pc;
    logic [31:0] result;
    logic        write_en;
    logic [3:0]  flags_nzcv;

    int checks = 0;
    int failures = 0;
    logic [3:0] mflags;  // model of held N Z C V
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    dp_alu_core uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .shift_carry(shift_carry), .shift_is_lsl0(shift_is_lsl0),
        .set_flags(set_flags), .dest_is_pc(dest_is_pc),
        .result(result), .write_en(write_en), .flags_nzcv(flags_nzcv)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        sc;
        logic        l0;
        logic        sf;
        logic        pc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'hD, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'h2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h5, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h6, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h7, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'hA, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h9, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'hF, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h3, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    function automatic logic is_arith(input logic [3:0] op);
        return (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
    endfunction

    // returns {result, c, v}
    function automatic logic [33:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic c_old);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint u, s;
        logic add;
        longint k;
        logic [31:0] r;
        add = 1'b0; k = 0; u = 0; s = 0;
        case (op)
            4'h4, 4'hB: begin add = 1; k = 0; end
            4'h5:       begin add = 1; k = longint'(c_old); end
            4'h2, 4'hA: begin u = ua - ub;     s = sa - sb; end
            4'h3:       begin u = ub - ua;     s = sb - sa; end
            4'h6:       begin u = ua - ub - longint'(!c_old); s = sa - sb - longint'(!c_old); end
            4'h7:       begin u = ub - ua - longint'(!c_old); s = sb - sa - longint'(!c_old); end
            default: ;
        endcase
        if (add) begin
            u = ua + ub + k; s = sa + sb + k;
        end
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC:       r = a | b;
            4'hD:       r = b;
            4'hE:       r = a & ~b;
            4'hF:       r = ~b;
            default:    r = u[31:0];
        endcase
        return {r,
                add ? (u >= 64'sh1_0000_0000) : (u >= 0),
                (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000)};
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        if (!is_arith(op)) return "R1";
        if (op >= 4'h5 && op <= 4'h7) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic l0, input logic sf, input logic pc);
        logic [33:0] m;
        logic [3:0]  nf;
        logic        upd;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b;
        shift_carry = sc; shift_is_lsl0 = l0; set_flags = sf; dest_is_pc = pc;
        m = model(op, a, b, mflags[1]);
        upd = sf && !pc;
        nf[3] = m[33];
        nf[2] = (m[33:2] == 32'h0);
        nf[1] = is_arith(op) ? m[1] : (l0 ? mflags[1] : sc);
        nf[0] = is_arith(op) ? m[0] : mflags[0];
        #5;
        check(res_tag(op), result, m[33:2]);
        check("R4", {31'b0, write_en}, {31'b0, op[3:2] != 2'b10});
        @(posedge clk);
        #2;
        if (upd) mflags = nf;
        check(!upd ? "R8" : (is_arith(op) ? "R5 R6" : "R5 R7"),
              {28'b0, flags_nzcv}, {28'b0, mflags});
    endtask

    task automatic set_carry(input logic c);
        apply(4'hD, 32'h1, 32'h1, c, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] corner [4];
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        rst_n = 1'b0; opcode = 4'h0; op_a = '0; op_b = '0;
        shift_carry = 1'b1; shift_is_lsl0 = 1'b0; set_flags = 1'b1; dest_is_pc = 1'b0;
        mflags = 4'b0000;
        repeat (3) @(posedge clk);
        #2;
        check("R9", {28'b0, flags_nzcv}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // stimulus table
        for (int i = 0; i < NV; i++)
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].sc, VEC[i].l0, VEC[i].sf, VEC[i].pc);

        // every opcode over corner operands and both held carries (R1 R2 R3 R6)
        for (int op = 0; op < 16; op++)
            for (int ia = 0; ia < 4; ia++)
                for (int ib = 0; ib < 4; ib++)
                    for (int c = 0; c < 2; c++) begin
                        set_carry(c[0]);
                        apply(op[3:0], corner[ia], corner[ib], c[0] ^ 1'b1, 1'b0, 1'b1, 1'b0);
                    end

        // random operands
        for (int i = 0; i < 300; i++)
            apply(4'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom));

        // R7: logical update after C and V set; lsl0 keeps C, V kept
        apply(4'h4, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 setup", {28'b0, flags_nzcv}, 32'h3);
        apply(4'hC, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R7", {28'b0, flags_nzcv}, 32'h7);
        apply(4'hD, 32'h0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7", {28'b0, flags_nzcv}, 32'h9);

        // R8: no update with set_flags clear or destination PC
        apply(4'h2, 32'h0, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", {28'b0, flags_nzcv}, 32'h9);
        apply(4'h2, 32'h0, 32'h1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R8", {28'b0, flags_nzcv}, 32'h9);

        // R9: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        check("R9", {28'b0, flags_nzcv}, 32'h0);
        mflags = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;
        set_carry(1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule